// File: doc/BRIEF.md
# Frame-Tagged Belt with Call and Return

This block is the operand belt of a statically scheduled core, extended so that function calls and returns move no stored data. Each stored value carries the id of the frame that owns it, plus a drop number within that frame. A read at belt position k returns the k-th most recent value of the current frame only. Changing the current frame id therefore empties the visible belt at once, while the caller's values stay where they are.

A call copies the listed argument positions into new entries tagged with the next frame id. The callee then sees only its arguments. A return drops the listed result values onto the caller's frame, which becomes current again. Entries of the finished frame are freed. Frame ids work as a stack, so depth and id are the same number. Interrupts and traps use the same call port, with hardware supplying the argument list.

Values whose operation was issued by a caller but which arrive while a callee runs are held back. They drop onto the caller's belt in the return cycle, after the returned results.

Top module: `frame_belt`

## Requirements
- R1: After reset `fid_o` is 0 and every read port reports `rd_vld_o` low with `rd_data_o` zero.
- R2: In a drop cycle, drop lanes land in ascending lane order, so the highest valid lane becomes position 0 and older values move up by the number of drops.
- R3: A position that holds no value of the current frame reads with `rd_vld_o` low and data zero. This covers positions never filled and values pushed past the last of BELT positions.
- R4: A call raises `fid_o` by one. The callee's belt then holds exactly `call_cnt_i` values: argument slot 0 is dropped first, so the last listed argument is position 0. All higher positions are empty.
- R5: An argument list may name the same caller position more than once, and each copy is a separate callee value.
- R6: A return lowers `fid_o` by one. Result slot 0 drops first onto the caller's belt, and the caller's earlier values sit above the results unchanged.
- R7: A drop carrying a frame id below the current one is invisible while the callee runs. It appears on that caller's belt at the return into it, dropped after the results, in arrival order.
- R8: A return frees the finished frame's values, so a later call at the same depth with no arguments reads all positions empty.
- R9: Calls nest up to NFRAME-1 levels above frame 0, and storage always has room for a cycle's writes. Returns unwind each level back to its caller's view.
- R10: Call, return and drops are mutually exclusive in a cycle, and every argument and result position named must hold a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drop_vld_i | input | NDROP | Per-lane drop valid |
| drop_data_i | input | NDROP*DW | Per-lane drop value |
| drop_fid_i | input | FW | Frame that issued this cycle's drops |
| rd_pos_i | input | NRD*PW | Belt position per read port |
| rd_data_o | output | NRD*DW | Value at that position, zero when empty |
| rd_vld_o | output | NRD | Position holds a value of the current frame |
| call_i | input | 1 | Call (voluntary or hardware-initiated) |
| call_cnt_i | input | AW | Number of arguments, 0..NARG |
| call_pos_i | input | NARG*PW | Caller positions of the arguments, slot 0 first |
| ret_i | input | 1 | Return |
| ret_cnt_i | input | RW | Number of results, 0..NRES |
| ret_pos_i | input | NRES*PW | Callee positions of the results, slot 0 first |
| fid_o | output | FW | Current frame id (call depth) |

## Verification
Every cycle, the assertions check several properties. The frame id moves by exactly one on each call and return. Depth stays inside the stack. No two stored values of a frame answer the same position. Free storage and hold space always cover the cycle's writes. Every named argument or result position resolves. Only the directed scenarios can show the visible ordering: lane order on drops, argument and result order including repeated positions, and the placement of held in-flight values behind the results. They also show that a callee sees none of its caller's values and that a re-entered depth starts empty.

// File: rtl/frame_belt_pkg.sv
package frame_belt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_DROP,
    OP_CALL,
    OP_RET
  } belt_op_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/belt_frames.sv
module belt_frames
  import frame_belt_pkg::*;
#(
  parameter int NFRAME = 4,
  parameter int CW     = 5,
  parameter int NWW    = 3,
  localparam int FW    = $clog2(NFRAME)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  belt_op_e       op_i,
  input  logic [NWW-1:0] wr_n_i,
  output logic [FW-1:0]  cur_o,
  output logic [CW-1:0]  cur_cnt_o,
  output logic [FW-1:0]  tgt_fid_o,
  output logic [CW-1:0]  tgt_base_o
);

  logic [FW-1:0] cur_q;
  logic [CW-1:0] cnt_q [NFRAME];

  always_comb begin
    unique case (op_i)
      OP_CALL: begin
        tgt_fid_o  = cur_q + FW'(1);
        tgt_base_o = '0;
      end
      OP_RET: begin
        tgt_fid_o  = cur_q - FW'(1);
        tgt_base_o = cnt_q[cur_q - FW'(1)];
      end
      default: begin
        tgt_fid_o  = cur_q;
        tgt_base_o = cnt_q[cur_q];
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      for (int f = 0; f < NFRAME; f++) cnt_q[f] <= '0;
    end else if (op_i != OP_IDLE) begin
      cnt_q[tgt_fid_o] <= tgt_base_o + CW'(wr_n_i);
      cur_q            <= tgt_fid_o;
    end
  end

  assign cur_o     = cur_q;
  assign cur_cnt_o = cnt_q[cur_q];

  // R4
  call_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CALL |=> cur_q == $past(cur_q) + FW'(1));
  // R6
  ret_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_RET |=> cur_q == $past(cur_q) - FW'(1));
  // R9
  depth_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CALL |-> cur_q != FW'(NFRAME - 1));
  // R9
  depth_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_RET |-> cur_q != '0);

endmodule

// File: rtl/belt_hold.sv
module belt_hold #(
  parameter int DW    = 32,
  parameter int NHOLD = 4,
  parameter int NDROP = 2,
  parameter int FW    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NDROP-1:0]            push_vld_i,
  input  logic [NDROP-1:0][DW-1:0]    push_data_i,
  input  logic [FW-1:0]               push_fid_i,
  input  logic                        rel_i,
  input  logic [FW-1:0]               rel_fid_i,
  output logic [NHOLD-1:0]            rel_vld_o,
  output logic [NHOLD-1:0][DW-1:0]    rel_data_o
);

  // slot 0 is the oldest held value
  logic [NHOLD-1:0]         hv_q, hv_d;
  logic [NHOLD-1:0][FW-1:0] hf_q, hf_d;
  logic [NHOLD-1:0][DW-1:0] hd_q, hd_d;

  always_comb begin
    for (int i = 0; i < NHOLD; i++) begin
      rel_vld_o[i]  = rel_i && hv_q[i] && (hf_q[i] == rel_fid_i);
      rel_data_o[i] = hd_q[i];
    end
  end

  always_comb begin
    int m;
    m    = 0;
    hv_d = '0;
    hf_d = '0;
    hd_d = '0;
    // on a return, drop what is released and what belonged to the finished frame
    for (int i = 0; i < NHOLD; i++) begin
      if (hv_q[i] && !(rel_i && hf_q[i] >= rel_fid_i)) begin
        hv_d[m] = 1'b1;
        hf_d[m] = hf_q[i];
        hd_d[m] = hd_q[i];
        m++;
      end
    end
    for (int d = 0; d < NDROP; d++) begin
      if (push_vld_i[d] && m < NHOLD) begin
        hv_d[m] = 1'b1;
        hf_d[m] = push_fid_i;
        hd_d[m] = push_data_i[d];
        m++;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hv_q <= '0;
      hf_q <= '0;
      hd_q <= '0;
    end else begin
      hv_q <= hv_d;
      hf_q <= hf_d;
      hd_q <= hd_d;
    end
  end

  // R7
  hold_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hv_q) + $countones(push_vld_i) <= NHOLD);

endmodule

// File: rtl/belt_store.sv
module belt_store #(
  parameter int DW     = 32,
  parameter int BELT   = 8,
  parameter int DEPTH  = 38,
  parameter int NW     = 6,
  parameter int NLK    = 8,
  parameter int CW     = 5,
  parameter int FW     = 2,
  parameter int PW     = 3,
  parameter int NWW    = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NW-1:0]            wr_vld_i,
  input  logic [NW-1:0][DW-1:0]    wr_data_i,
  input  logic [FW-1:0]            tgt_fid_i,
  input  logic [CW-1:0]            tgt_base_i,
  input  logic                     clr_vld_i,
  input  logic [FW-1:0]            clr_fid_i,
  input  logic [FW-1:0]            lk_fid_i,
  input  logic [CW-1:0]            lk_cnt_i,
  input  logic [NLK-1:0][PW-1:0]   lk_pos_i,
  output logic [NLK-1:0][DW-1:0]   lk_data_o,
  output logic [NLK-1:0]           lk_hit_o,
  output logic [NWW-1:0]           wr_n_o
);

  logic [DEPTH-1:0]          vld_q;
  logic [DEPTH-1:0][FW-1:0]  fid_q;
  logic [DEPTH-1:0][CW-1:0]  num_q;
  logic [DEPTH-1:0][DW-1:0]  dat_q;

  logic [NW-1:0][DW-1:0]     cdat;
  int                        n_wr;
  logic [DEPTH-1:0]          slot_wr, slot_kill;
  logic [DEPTH-1:0][NWW-1:0] slot_idx;
  logic [CW-1:0]             new_cnt;
  logic [NLK-1:0][DEPTH-1:0] match;
  int                        free_cnt;

  // pack valid writes, keeping their order
  always_comb begin
    n_wr = 0;
    cdat = '0;
    for (int w = 0; w < NW; w++) begin
      if (wr_vld_i[w]) begin
        cdat[n_wr] = wr_data_i[w];
        n_wr++;
      end
    end
  end
  assign wr_n_o  = NWW'(n_wr);
  assign new_cnt = tgt_base_i + CW'(n_wr);

  // k-th free slot takes k-th write; old values of the target frame fall off
  always_comb begin
    int rank;
    logic [CW-1:0] age_new;
    rank      = 0;
    free_cnt  = 0;
    slot_wr   = '0;
    slot_idx  = '0;
    slot_kill = '0;
    for (int s = 0; s < DEPTH; s++) begin
      age_new = new_cnt - CW'(1) - num_q[s];
      if (!vld_q[s]) begin
        free_cnt++;
        if (rank < n_wr) begin
          slot_wr[s]  = 1'b1;
          slot_idx[s] = NWW'(rank);
        end
        rank++;
      end else begin
        slot_kill[s] = (clr_vld_i && fid_q[s] == clr_fid_i) ||
                       (n_wr != 0 && fid_q[s] == tgt_fid_i && age_new >= CW'(BELT));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      fid_q <= '0;
      num_q <= '0;
      dat_q <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (slot_wr[s]) begin
          vld_q[s] <= 1'b1;
          fid_q[s] <= tgt_fid_i;
          num_q[s] <= tgt_base_i + CW'(slot_idx[s]);
          dat_q[s] <= cdat[slot_idx[s]];
        end else if (slot_kill[s]) begin
          vld_q[s] <= 1'b0;
        end
      end
    end
  end

  // position = age within the current frame
  always_comb begin
    for (int k = 0; k < NLK; k++) begin
      lk_hit_o[k]  = 1'b0;
      lk_data_o[k] = '0;
      for (int s = 0; s < DEPTH; s++) begin
        match[k][s] = vld_q[s] && fid_q[s] == lk_fid_i &&
                      (lk_cnt_i - CW'(1) - num_q[s]) == CW'(lk_pos_i[k]);
        if (match[k][s]) begin
          lk_hit_o[k]  = 1'b1;
          lk_data_o[k] = dat_q[s];
        end
      end
    end
  end

  // R9
  store_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_wr <= free_cnt);

  for (genvar k = 0; k < NLK; k++) begin : g_uniq
    // R2
    unique_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(match[k]) <= 1);
  end

endmodule

// File: rtl/frame_belt.sv
module frame_belt
  import frame_belt_pkg::*;
#(
  parameter int DW     = 32,
  parameter int BELT   = 8,
  parameter int NFRAME = 4,
  parameter int NDROP  = 2,
  parameter int NRD    = 2,
  parameter int NARG   = 4,
  parameter int NRES   = 2,
  parameter int NHOLD  = 4,
  localparam int PW    = $clog2(BELT),
  localparam int FW    = $clog2(NFRAME),
  localparam int AW    = $clog2(NARG + 1),
  localparam int RW    = $clog2(NRES + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NDROP-1:0]         drop_vld_i,
  input  logic [NDROP-1:0][DW-1:0] drop_data_i,
  input  logic [FW-1:0]            drop_fid_i,
  input  logic [NRD-1:0][PW-1:0]   rd_pos_i,
  output logic [NRD-1:0][DW-1:0]   rd_data_o,
  output logic [NRD-1:0]           rd_vld_o,
  input  logic                     call_i,
  input  logic [AW-1:0]            call_cnt_i,
  input  logic [NARG-1:0][PW-1:0]  call_pos_i,
  input  logic                     ret_i,
  input  logic [RW-1:0]            ret_cnt_i,
  input  logic [NRES-1:0][PW-1:0]  ret_pos_i,
  output logic [FW-1:0]            fid_o
);

  localparam int NW    = max3(NDROP, NARG, NRES + NHOLD);
  localparam int NWW   = $clog2(NW + 1);
  localparam int CW    = $clog2(BELT) + 2;
  localparam int DEPTH = BELT * NFRAME + NW;
  localparam int NLK   = NRD + NARG + NRES;
  localparam int ARG0  = NRD;
  localparam int RES0  = NRD + NARG;

  belt_op_e                 op;
  logic [FW-1:0]            cur, tgt_fid;
  logic [CW-1:0]            cur_cnt, tgt_base;
  logic [NWW-1:0]           wr_n;
  logic [NW-1:0]            wr_vld;
  logic [NW-1:0][DW-1:0]    wr_data;
  logic [NLK-1:0][PW-1:0]   lk_pos;
  logic [NLK-1:0][DW-1:0]   lk_data;
  logic [NLK-1:0]           lk_hit;
  logic                     drop_here, drop_late;
  logic [NDROP-1:0]         push_vld;
  logic [NHOLD-1:0]         rel_vld;
  logic [NHOLD-1:0][DW-1:0] rel_data;

  always_comb begin
    if (call_i)          op = OP_CALL;
    else if (ret_i)      op = OP_RET;
    else if (|drop_vld_i) op = OP_DROP;
    else                 op = OP_IDLE;
  end

  assign drop_here = (op == OP_DROP) && (drop_fid_i == cur);
  assign drop_late = (op == OP_DROP) && (drop_fid_i < cur);
  assign push_vld  = drop_vld_i & {NDROP{drop_late}};
  assign lk_pos    = {ret_pos_i, call_pos_i, rd_pos_i};

  always_comb begin
    wr_vld  = '0;
    wr_data = '0;
    unique case (op)
      OP_DROP: begin
        for (int i = 0; i < NDROP; i++) begin
          wr_vld[i]  = drop_vld_i[i] && drop_here;
          wr_data[i] = drop_data_i[i];
        end
      end
      OP_CALL: begin
        for (int i = 0; i < NARG; i++) begin
          wr_vld[i]  = i < int'(call_cnt_i);
          wr_data[i] = lk_data[ARG0 + i];
        end
      end
      OP_RET: begin
        for (int i = 0; i < NRES; i++) begin
          wr_vld[i]  = i < int'(ret_cnt_i);
          wr_data[i] = lk_data[RES0 + i];
        end
        // held in-flight values follow the results
        for (int h = 0; h < NHOLD; h++) begin
          wr_vld[NRES + h]  = rel_vld[h];
          wr_data[NRES + h] = rel_data[h];
        end
      end
      default: ;
    endcase
  end

  belt_frames #(.NFRAME(NFRAME), .CW(CW), .NWW(NWW)) u_frames (
    .clk_i, .rst_ni,
    .op_i      (op),
    .wr_n_i    (wr_n),
    .cur_o     (cur),
    .cur_cnt_o (cur_cnt),
    .tgt_fid_o (tgt_fid),
    .tgt_base_o(tgt_base)
  );

  belt_hold #(.DW(DW), .NHOLD(NHOLD), .NDROP(NDROP), .FW(FW)) u_hold (
    .clk_i, .rst_ni,
    .push_vld_i (push_vld),
    .push_data_i(drop_data_i),
    .push_fid_i (drop_fid_i),
    .rel_i      (op == OP_RET),
    .rel_fid_i  (cur - FW'(1)),
    .rel_vld_o  (rel_vld),
    .rel_data_o (rel_data)
  );

  belt_store #(
    .DW(DW), .BELT(BELT), .DEPTH(DEPTH), .NW(NW), .NLK(NLK),
    .CW(CW), .FW(FW), .PW(PW), .NWW(NWW)
  ) u_store (
    .clk_i, .rst_ni,
    .wr_vld_i  (wr_vld),
    .wr_data_i (wr_data),
    .tgt_fid_i (tgt_fid),
    .tgt_base_i(tgt_base),
    .clr_vld_i (op == OP_RET),
    .clr_fid_i (cur),
    .lk_fid_i  (cur),
    .lk_cnt_i  (cur_cnt),
    .lk_pos_i  (lk_pos),
    .lk_data_o (lk_data),
    .lk_hit_o  (lk_hit),
    .wr_n_o    (wr_n)
  );

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r] = lk_data[r];
    assign rd_vld_o[r]  = lk_hit[r];
  end
  assign fid_o = cur;

  // R10
  op_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i || ret_i) |-> !(call_i && ret_i) && drop_vld_i == '0);

  for (genvar a = 0; a < NARG; a++) begin : g_arg_chk
    // R10
    arg_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (call_i && a < int'(call_cnt_i)) |-> lk_hit[ARG0 + a]);
  end
  for (genvar q = 0; q < NRES; q++) begin : g_res_chk
    // R10
    res_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ret_i && q < int'(ret_cnt_i)) |-> lk_hit[RES0 + q]);
  end

endmodule

// File: tb/frame_belt_test.sv
module frame_belt_test;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [1:0]        drop_vld_i = '0;
  logic [1:0][31:0]  drop_data_i = '0;
  logic [1:0]        drop_fid_i = '0;
  logic [1:0][2:0]   rd_pos_i = '0;
  logic [1:0][31:0]  rd_data_o;
  logic [1:0]        rd_vld_o;
  logic              call_i = 1'b0;
  logic [2:0]        call_cnt_i = '0;
  logic [3:0][2:0]   call_pos_i = '0;
  logic              ret_i = 1'b0;
  logic [1:0]        ret_cnt_i = '0;
  logic [1:0][2:0]   ret_pos_i = '0;
  logic [1:0]        fid_o;

  int total = 0;
  int bad   = 0;

  frame_belt uut (.*);

  always #4 clk_i = ~clk_i;

  task automatic check_rd(input int port, input int pos, input logic ev,
                          input logic [31:0] ed, input string req);
    rd_pos_i[port] = 3'(pos);
    #1;
    total++;
    if (rd_vld_o[port] !== ev || rd_data_o[port] !== (ev ? ed : 32'd0)) begin
      bad++;
      $display("FAIL %s: port %0d b%0d got vld=%0b data=%0d expected vld=%0b data=%0d",
               req, port, pos, rd_vld_o[port], rd_data_o[port], ev, ev ? ed : 32'd0);
    end
  endtask

  task automatic check_fid(input logic [1:0] ef, input string req);
    total++;
    if (fid_o !== ef) begin
      bad++;
      $display("FAIL %s: fid got %0d expected %0d", req, fid_o, ef);
    end
  endtask

  task automatic drop(input logic [1:0] vld, input logic [31:0] d0,
                      input logic [31:0] d1, input logic [1:0] f);
    @(negedge clk_i);
    drop_vld_i = vld; drop_data_i[0] = d0; drop_data_i[1] = d1; drop_fid_i = f;
    @(negedge clk_i);
    drop_vld_i = '0;
  endtask

  task automatic call(input int cnt, input int p0, input int p1, input int p2, input int p3);
    @(negedge clk_i);
    call_i = 1'b1; call_cnt_i = 3'(cnt);
    call_pos_i[0] = 3'(p0); call_pos_i[1] = 3'(p1);
    call_pos_i[2] = 3'(p2); call_pos_i[3] = 3'(p3);
    @(negedge clk_i);
    call_i = 1'b0;
  endtask

  task automatic ret(input int cnt, input int p0, input int p1);
    @(negedge clk_i);
    ret_i = 1'b1; ret_cnt_i = 2'(cnt);
    ret_pos_i[0] = 3'(p0); ret_pos_i[1] = 3'(p1);
    @(negedge clk_i);
    ret_i = 1'b0;
  endtask

  task automatic t_reset();
    check_fid(2'd0, "R1");
    check_rd(0, 0, 1'b0, 0, "R1");
    check_rd(1, 7, 1'b0, 0, "R1");
  endtask

  task automatic t_drops();
    drop(2'b11, 32'd10, 32'd11, 2'd0);
    check_rd(0, 0, 1'b1, 32'd11, "R2");
    check_rd(0, 1, 1'b1, 32'd10, "R2");
    drop(2'b01, 32'd12, 32'd0, 2'd0);
    check_rd(0, 0, 1'b1, 32'd12, "R2");
    check_rd(1, 2, 1'b1, 32'd10, "R2");
    check_rd(0, 3, 1'b0, 0, "R3");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 8; i++) drop(2'b01, 32'(20 + i), 32'd0, 2'd0);
    check_rd(0, 0, 1'b1, 32'd27, "R3");
    check_rd(1, 7, 1'b1, 32'd20, "R3");
  endtask

  task automatic t_call_args();
    call(4, 1, 5, 3, 3);   // values 26, 22, 24, 24
    check_fid(2'd1, "R4");
    check_rd(0, 0, 1'b1, 32'd24, "R5");
    check_rd(0, 1, 1'b1, 32'd24, "R5");
    check_rd(0, 2, 1'b1, 32'd22, "R4");
    check_rd(1, 3, 1'b1, 32'd26, "R4");
    check_rd(0, 4, 1'b0, 0, "R4");
  endtask

  task automatic t_inflight();
    drop(2'b01, 32'd99, 32'd0, 2'd0);
    check_rd(0, 0, 1'b1, 32'd24, "R7");
    check_rd(0, 4, 1'b0, 0, "R7");
    drop(2'b01, 32'd50, 32'd0, 2'd1);
    check_rd(0, 0, 1'b1, 32'd50, "R2");
    check_rd(0, 4, 1'b1, 32'd26, "R2");
  endtask

  task automatic t_return();
    ret(2, 0, 4);          // results 50, 26, then held 99
    check_fid(2'd0, "R6");
    check_rd(0, 0, 1'b1, 32'd99, "R7");
    check_rd(0, 1, 1'b1, 32'd26, "R6");
    check_rd(0, 2, 1'b1, 32'd50, "R6");
    check_rd(0, 3, 1'b1, 32'd27, "R6");
    check_rd(1, 7, 1'b1, 32'd23, "R6");
  endtask

  task automatic t_nest();
    call(0, 0, 0, 0, 0);
    check_fid(2'd1, "R8");
    check_rd(0, 0, 1'b0, 0, "R8");
    drop(2'b01, 32'd70, 32'd0, 2'd1);
    call(1, 0, 0, 0, 0);
    call(1, 0, 0, 0, 0);
    check_fid(2'd3, "R9");
    check_rd(0, 0, 1'b1, 32'd70, "R9");
    check_rd(0, 1, 1'b0, 0, "R9");
    ret(1, 0, 0);
    check_fid(2'd2, "R9");
    check_rd(0, 0, 1'b1, 32'd70, "R9");
    check_rd(0, 1, 1'b1, 32'd70, "R9");
    ret(0, 0, 0);
    check_rd(0, 0, 1'b1, 32'd70, "R9");
    check_rd(0, 1, 1'b0, 0, "R9");
    ret(0, 0, 0);
    check_fid(2'd0, "R9");
    check_rd(0, 0, 1'b1, 32'd99, "R9");
    check_rd(1, 7, 1'b1, 32'd23, "R9");
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    t_reset();
    t_drops();
    t_fill();
    t_call_args();
    t_inflight();
    t_return();
    t_nest();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule